// File: doc/BRIEF.md
# I2C Slave Clock Stretch Controller

This block sits beside the bit engine of an I2C target device and decides when the target pulls SCL low to pause the bus, and why. It watches three conditions. The first is the opening of a read data phase. The second is an empty transmit queue while the controller is reading. The third is a full receive queue while the controller is writing. When stretching is enabled and one of these conditions appears while SCL is already low, the block holds SCL low. It also stores a two-bit reason code and emits a one-cycle interrupt pulse.

The hold ends when software writes a one-shot clear, or when the condition that caused it disappears. After that, SCL stays low for a programmable number of extra module clocks before it is let go. The same block also chooses the ACK level the target returns after each byte: either the level the bit engine proposes, or a fixed level set by software. Address matching, byte shifting and the queues themselves belong to neighbouring blocks. The queues appear here only as level inputs.

Top module: `i2cs_stretch_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `scl_hold` is 0, `stretch_irq` is 0 and `stretch_cause` is 3 (no stretch yet).
- R2: With `stretch_en` at 0, no condition starts a hold. A read-phase start seen while disabled is dropped and does not cause a hold when stretching is enabled later.
- R3: A hold starts only while `scl_in` is 0. A read-phase start pulse that arrives while `scl_in` is 1 is remembered, and the hold begins once `scl_in` goes low.
- R4: Reason codes: 0 = read data phase start, 1 = transmit queue empty with `in_read`=1, 2 = receive queue full with `in_read`=0. A transmit-empty input with `in_read`=0, or a receive-full input with `in_read`=1, starts no hold.
- R5: When more than one condition is present in the same cycle, the read-phase start wins, then transmit-empty, then receive-full.
- R6: `scl_hold` and `stretch_irq` rise on the clock edge that samples the starting condition. `stretch_irq` lasts exactly one cycle.
- R7: A one-cycle `stretch_clr` pulse ends any hold, whatever its reason.
- R8: A hold with reason 1 or 2 also ends when its condition input falls. A hold with reason 0 ends only through `stretch_clr`.
- R9: After the edge that samples the end condition, `scl_hold` stays 1 for exactly `protect_cnt` more cycles. A value of 0 releases SCL on that same edge.
- R10: Only one hold may start per SCL low phase. After a release, a new hold needs `scl_in` to have been 1 first, even if a condition is still present.
- R11: `stretch_cause` keeps the code of the most recent hold after SCL is released.
- R12: `ack_out` equals `ack_lvl` when `ack_ctl_en` is 1, and `ack_auto` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| stretch_en | input | 1 | Allows holds to start |
| stretch_clr | input | 1 | One-shot software release |
| protect_cnt | input | 10 | Extra low cycles after a release condition |
| scl_in | input | 1 | Filtered SCL line level |
| in_read | input | 1 | 1 when the current transfer is a controller read |
| rd_phase_start | input | 1 | Pulse at the opening of a read data phase |
| tx_empty | input | 1 | Transmit queue empty level |
| rx_full | input | 1 | Receive queue full level |
| ack_ctl_en | input | 1 | Selects the software ACK level |
| ack_lvl | input | 1 | Software ACK level |
| ack_auto | input | 1 | ACK level proposed by the bit engine |
| scl_hold | output | 1 | 1 = drive SCL low |
| stretch_cause | output | 2 | Reason for the latest hold, 3 = none |
| stretch_irq | output | 1 | One-cycle pulse at the start of a hold |
| ack_out | output | 1 | ACK level to return |

## Verification
A read-phase start and an empty transmit queue can be sampled on the same edge during a read. The bench raises both together with SCL low and expects reason code 0. It also raises both queue flags during a write and expects code 2.

A software clear can also land in a cycle where a stretch condition is still present. The bench releases a transmit-empty hold by the clear while keeping the queue empty and SCL low. It expects the line to stay released until SCL has been high once, and then expects a fresh hold with its own interrupt pulse.

// File: rtl/i2cs_stretch_pkg.sv
package i2cs_stretch_pkg;

    localparam int NUM_EVENTS = 3;

    typedef enum logic [1:0] {
        CAUSE_RD_START = 2'd0,
        CAUSE_TX_EMPTY = 2'd1,
        CAUSE_RX_FULL  = 2'd2,
        CAUSE_NONE     = 2'd3
    } stretch_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_GUARD = 2'd2
    } hold_state_e;

    // bit order of the event vector is also the priority order (bit 0 wins)
    typedef struct packed {
        logic rx_full;
        logic tx_empty;
        logic rd_start;
    } event_vec_t;

    function automatic stretch_cause_e pick_cause(input event_vec_t ev);
        stretch_cause_e c;
        if (ev.rd_start)      c = CAUSE_RD_START;
        else if (ev.tx_empty) c = CAUSE_TX_EMPTY;
        else if (ev.rx_full)  c = CAUSE_RX_FULL;
        else                  c = CAUSE_NONE;
        return c;
    endfunction

    // true while the condition behind a level-type hold is still present
    function automatic logic cond_present(input stretch_cause_e c,
                                          input logic tx_empty,
                                          input logic rx_full,
                                          input logic in_read);
        logic p;
        case (c)
            CAUSE_TX_EMPTY: p = tx_empty & in_read;
            CAUSE_RX_FULL:  p = rx_full & ~in_read;
            CAUSE_RD_START: p = 1'b1;
            default:        p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/stretch_event_qual.sv
module stretch_event_qual
    import i2cs_stretch_pkg::*;
(
    input  logic           rd_start,
    input  logic           tx_empty,
    input  logic           rx_full,
    input  logic           in_read,
    output event_vec_t     ev,
    output logic           ev_any,
    output stretch_cause_e winner
);
    logic [NUM_EVENTS-1:0] ev_bits;

    always_comb begin
        ev.rd_start = rd_start;
        ev.tx_empty = tx_empty & in_read;
        ev.rx_full  = rx_full & ~in_read;
    end

    assign ev_bits = ev;

    genvar g;
    logic [NUM_EVENTS:0] any_chain;
    assign any_chain[0] = 1'b0;
    generate
        for (g = 0; g < NUM_EVENTS; g++) begin : g_any
            assign any_chain[g+1] = any_chain[g] | ev_bits[g];
        end
    endgenerate

    assign ev_any = any_chain[NUM_EVENTS];
    assign winner = pick_cause(ev);
endmodule

// File: rtl/stretch_guard_timer.sv
module stretch_guard_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);
endmodule

// File: rtl/stretch_ack_sel.sv
module stretch_ack_sel (
    input  logic ack_ctl_en,
    input  logic ack_lvl,
    input  logic ack_auto,
    output logic ack_out
);
    always_comb begin
        if (ack_ctl_en) ack_out = ack_lvl;
        else            ack_out = ack_auto;
    end
endmodule

// File: rtl/i2cs_stretch_ctrl.sv
module i2cs_stretch_ctrl
    import i2cs_stretch_pkg::*;
#(
    parameter int PROT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stretch_en,
    input  logic              stretch_clr,
    input  logic [PROT_W-1:0] protect_cnt,
    input  logic              scl_in,
    input  logic              in_read,
    input  logic              rd_phase_start,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              ack_ctl_en,
    input  logic              ack_lvl,
    input  logic              ack_auto,
    output logic              scl_hold,
    output logic [1:0]        stretch_cause,
    output logic              stretch_irq,
    output logic              ack_out
);
    hold_state_e    state_q, state_d;
    stretch_cause_e cause_q;
    event_vec_t     ev;
    stretch_cause_e winner;
    logic           ev_any;
    logic           pend_q;
    logic           arm_q;
    logic           hold_q;
    logic           irq_q;
    logic           start_ok;
    logic           release_now;
    logic           guard_load;
    logic           guard_last;

    stretch_event_qual u_qual (
        .rd_start (rd_phase_start | pend_q),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .in_read  (in_read),
        .ev       (ev),
        .ev_any   (ev_any),
        .winner   (winner)
    );

    stretch_guard_timer #(.CNT_W(PROT_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .load     (guard_load),
        .load_val (protect_cnt),
        .last     (guard_last)
    );

    stretch_ack_sel u_ack (
        .ack_ctl_en (ack_ctl_en),
        .ack_lvl    (ack_lvl),
        .ack_auto   (ack_auto),
        .ack_out    (ack_out)
    );

    assign start_ok = (state_q == ST_IDLE) & stretch_en & arm_q & ~scl_in & ev_any;
    assign release_now = stretch_clr | ~cond_present(cause_q, tx_empty, rx_full, in_read);
    assign guard_load = (state_q == ST_HOLD) & release_now & (protect_cnt != '0);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (release_now) begin
                    if (protect_cnt == '0) state_d = ST_IDLE;
                    else                   state_d = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (guard_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            pend_q  <= 1'b0;
            arm_q   <= 1'b1;
            hold_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hold_q  <= (state_d != ST_IDLE);
            irq_q   <= start_ok;
            if (start_ok) cause_q <= winner;

            if (start_ok)    arm_q <= 1'b0;
            else if (scl_in) arm_q <= 1'b1;

            if (!stretch_en || start_ok) pend_q <= 1'b0;
            else if (rd_phase_start)     pend_q <= 1'b1;
        end
    end

    assign scl_hold      = hold_q;
    assign stretch_irq   = irq_q;
    assign stretch_cause = cause_q;
endmodule

// File: rtl/i2cs_stretch_chk.sv
module i2cs_stretch_chk (
    input logic       clk,
    input logic       rst,
    input logic       stretch_en,
    input logic       scl_in,
    input logic       scl_hold,
    input logic       stretch_irq,
    input logic [1:0] stretch_cause
);
    // R3
    hold_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> $past(!scl_in));

    // R2
    hold_rise_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> $past(stretch_en));

    // R6
    irq_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> stretch_irq);

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        stretch_irq |=> !stretch_irq);

    // R4
    cause_known_chk: assert property (@(posedge clk) disable iff (rst)
        scl_hold |-> (stretch_cause != 2'd3));
endmodule

bind i2cs_stretch_ctrl i2cs_stretch_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .stretch_en    (stretch_en),
    .scl_in        (scl_in),
    .scl_hold      (scl_hold),
    .stretch_irq   (stretch_irq),
    .stretch_cause (stretch_cause)
);

// File: tb/i2cs_stretch_ctrl_test.sv
module i2cs_stretch_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stretch_en = 1'b0, stretch_clr = 1'b0;
    logic [PW-1:0] protect_cnt = '0;
    logic scl_in = 1'b1, in_read = 1'b0, rd_phase_start = 1'b0;
    logic tx_empty = 1'b0, rx_full = 1'b0;
    logic ack_ctl_en = 1'b0, ack_lvl = 1'b0, ack_auto = 1'b0;
    logic scl_hold, stretch_irq, ack_out;
    logic [1:0] stretch_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_stretch_ctrl #(.PROT_W(PW)) uut (
        .clk(clk), .rst(rst), .stretch_en(stretch_en), .stretch_clr(stretch_clr),
        .protect_cnt(protect_cnt), .scl_in(scl_in), .in_read(in_read),
        .rd_phase_start(rd_phase_start), .tx_empty(tx_empty), .rx_full(rx_full),
        .ack_ctl_en(ack_ctl_en), .ack_lvl(ack_lvl), .ack_auto(ack_auto),
        .scl_hold(scl_hold), .stretch_cause(stretch_cause),
        .stretch_irq(stretch_irq), .ack_out(ack_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_bus();
        tx_empty = 1'b0; rx_full = 1'b0; rd_phase_start = 1'b0;
        stretch_clr = 1'b0; scl_in = 1'b1;
        step();
    endtask

    // kind: 0 read start, 1 tx empty, 2 rx full; by_clr: release by software clear
    task automatic run_stretch(input int kind, input int prot, input bit by_clr);
        int n;
        stretch_en = 1'b1;
        idle_bus();
        protect_cnt = PW'(prot);
        scl_in = 1'b0;
        case (kind)
            0: begin in_read = 1'b1; rd_phase_start = 1'b1; end
            1: begin in_read = 1'b1; tx_empty = 1'b1; end
            default: begin in_read = 1'b0; rx_full = 1'b1; end
        endcase
        step();
        rd_phase_start = 1'b0;
        chk("R4 hold", int'(scl_hold), 1);
        chk("R4 cause", int'(stretch_cause), kind);
        chk("R6 irq rise", int'(stretch_irq), 1);
        step();
        chk("R6 irq single", int'(stretch_irq), 0);
        chk("R8 still held", int'(scl_hold), 1);
        if (by_clr) stretch_clr = 1'b1;
        else if (kind == 1) tx_empty = 1'b0;
        else rx_full = 1'b0;
        step();
        stretch_clr = 1'b0;
        n = 0;
        while (scl_hold && n < 2000) begin
            n++;
            step();
        end
        chk(by_clr ? "R7 R9 protect after clear" : "R8 R9 protect after drop", n, prot);
        chk("R11 cause kept", int'(stretch_cause), kind);
        idle_bus();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int prots[5] = '{0, 1, 2, 3, 7};
        step();
        chk("R1 hold in reset", int'(scl_hold), 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 hold", int'(scl_hold), 0);
        chk("R1 irq", int'(stretch_irq), 0);
        chk("R1 cause", int'(stretch_cause), 3);

        // sweep reasons, protect counts and release kinds
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < 5; p++) begin
                run_stretch(k, prots[p], 1'b1);
                if (k != 0) run_stretch(k, prots[p], 1'b0);
            end
        end

        // R8: read-start hold ignores condition removal
        protect_cnt = '0;
        scl_in = 1'b0; in_read = 1'b1; rd_phase_start = 1'b1;
        step();
        rd_phase_start = 1'b0; in_read = 1'b0;
        repeat (4) step();
        chk("R8 read start needs clear", int'(scl_hold), 1);
        stretch_clr = 1'b1; step(); stretch_clr = 1'b0; step();
        chk("R8 read start released", int'(scl_hold), 0);
        idle_bus();

        // R5 priority: read start and tx empty together
        in_read = 1'b1; scl_in = 1'b0; rd_phase_start = 1'b1; tx_empty = 1'b1;
        step();
        rd_phase_start = 1'b0;
        chk("R5 read start beats tx empty", int'(stretch_cause), 0);
        stretch_clr = 1'b1; step(); idle_bus();

        // R5/R4: both queue flags during a write
        in_read = 1'b0; scl_in = 1'b0; tx_empty = 1'b1; rx_full = 1'b1;
        step();
        chk("R5 write picks rx full", int'(stretch_cause), 2);
        chk("R5 write hold", int'(scl_hold), 1);
        stretch_clr = 1'b1; step(); idle_bus();

        // R4: rx full during a read starts nothing
        in_read = 1'b1; scl_in = 1'b0; rx_full = 1'b1;
        repeat (3) step();
        chk("R4 rx full in read ignored", int'(scl_hold), 0);
        chk("R4 irq quiet", int'(stretch_irq), 0);
        idle_bus();

        // R3: read start while SCL high is deferred
        in_read = 1'b1; scl_in = 1'b1; rd_phase_start = 1'b1;
        step();
        rd_phase_start = 1'b0;
        chk("R3 no hold while high", int'(scl_hold), 0);
        step();
        chk("R3 still waiting", int'(scl_hold), 0);
        scl_in = 1'b0;
        step();
        chk("R3 deferred hold", int'(scl_hold), 1);
        chk("R3 deferred cause", int'(stretch_cause), 0);
        chk("R3 deferred irq", int'(stretch_irq), 1);
        stretch_clr = 1'b1; step(); idle_bus();

        // R10: clear while tx still empty, SCL stays low
        in_read = 1'b1; scl_in = 1'b0; tx_empty = 1'b1;
        step();
        chk("R10 first hold", int'(scl_hold), 1);
        stretch_clr = 1'b1; step(); stretch_clr = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R10 no re-hold in same low phase", int'(scl_hold), 0);
        end
        scl_in = 1'b1; step();
        scl_in = 1'b0; step();
        chk("R10 re-hold after high", int'(scl_hold), 1);
        chk("R10 new irq", int'(stretch_irq), 1);
        stretch_clr = 1'b1; step(); idle_bus();

        // R2: disabled, then enabling does not revive a dropped read start
        stretch_en = 1'b0;
        in_read = 1'b1; scl_in = 1'b0; tx_empty = 1'b1; rd_phase_start = 1'b1;
        step();
        rd_phase_start = 1'b0;
        repeat (3) step();
        chk("R2 no hold when disabled", int'(scl_hold), 0);
        chk("R2 cause unchanged", int'(stretch_cause), 1);
        tx_empty = 1'b0; step();
        stretch_en = 1'b1;
        repeat (3) step();
        chk("R2 dropped read start", int'(scl_hold), 0);
        idle_bus();

        // R12: ACK selection sweep
        for (int v = 0; v < 8; v++) begin
            ack_ctl_en = v[2]; ack_lvl = v[1]; ack_auto = v[0];
            #1;
            chk("R12 ack", int'(ack_out), v[2] ? int'(v[1]) : int'(v[0]));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule